// File: doc/BRIEF.md
# Transmit Descriptor Ring Scanner

This block is the transmit side of a network controller's DMA engine. Software leaves frame descriptors in a ring of sixteen 8-byte entries in memory and then pulses a kick. If the controller is not stopped, the scanner walks the ring from its current pointer. For each descriptor it reads one byte at a time through a simple request/acknowledge memory port. For each descriptor that the host has handed over, it decodes the buffer length and buffer address. It then streams the buffer bytes out on a valid/ready byte stream, returns the descriptor to the host and pulses a done event.

The ring sits at a fixed offset from a memory base. That base is the sum of the controller's 32-bit init pointer and a separate DMA offset. Both inputs must stay constant while the scanner is busy. Sixteen-bit descriptor fields are stored with the high byte at the lower address.

The output stream follows valid/ready rules. A byte is transferred on a clock edge where both valid and ready are high. While valid is high and ready is low, the data and last flag hold their values. Valid never drops without a transfer. The consumer may hold ready low for any length of time, and the scanner then waits without losing data. The memory port follows the same idea. A request stays asserted with a stable address, direction and write data until the cycle in which acknowledge is high. On a read, the data is taken in that same cycle.

Top module: `txr_ring_scan`

## Requirements
- R1: After reset, busy_o, tx_valid_o, mem_req_o and tx_done_o are low and ptr_o is 0; while busy_o is low, no memory request and no stream byte are issued.
- R2: A kick while stopped_i is high is ignored and not remembered: busy_o stays low and no memory access takes place.
- R3: A descriptor is sent only when its status byte (descriptor offset 2) is exactly 0x83. Any other status value is left untouched, and that descriptor produces no bytes.
- R4: The length field (offsets 4 and 5, high byte first) holds the negated byte count, so the frame length is the bitwise inverse of the field plus 1, in 16 bits. The buffer address is base + {offset 3 byte, offset 0 byte, offset 1 byte}. The bytes are streamed in increasing address order.
- R5: A decoded length above 1544 is cut to exactly 1544 bytes.
- R6: After a frame, the scanner writes 0x03 to the status byte and pulses tx_done_o for one cycle. In that same cycle ptr_o has advanced by 1 modulo 16. ptr_o changes at no other time, so skipped descriptors do not move it.
- R7: One scan visits at most 15 entries, starting at ptr_o and wrapping modulo 16. A fully handed-over ring therefore yields 15 frames per kick.
- R8: A kick while busy_o is high is held, and one further scan starts from the updated pointer when the current scan ends.
- R9: On the stream, tx_data_o and tx_last_o hold while tx_valid_o is high and tx_ready_i is low. tx_last_o marks the final byte of each frame. A zero-length frame emits no bytes but is still returned.
- R10: mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o hold until mem_ack_i is high.
- R11: Descriptor i lies at init_ptr_i + dma_off_i + RING_OFS + 8*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick_i | input | 1 | One-cycle request to scan the ring |
| stopped_i | input | 1 | Controller is in the stopped state |
| init_ptr_i | input | 32 | Init pointer, first term of the memory base |
| dma_off_i | input | 32 | DMA offset, second term of the memory base |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_ack_i | input | 1 | Request completed; read data valid |
| mem_rdata_i | input | 8 | Read data |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream consumer ready |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of a frame |
| tx_done_o | output | 1 | One-cycle pulse per returned frame |
| busy_o | output | 1 | A scan is in progress |
| ptr_o | output | 4 | Current ring pointer |

## Verification
The scanner is driven with several ring contents. One ring has a single ready entry that is not at the pointer, which shows whether the pointer advances once per frame or per visited entry. Another mixes near-miss status values, a zero length and an oversize length, which exposes errors in exact-match eligibility, two's-complement decoding and the cap. A fully handed-over ring, with one kick and then with a second kick during the scan, tells apart the 15-entry scan window and the held kick. Random rings under random acknowledge and ready stalls are compared byte by byte, together with the last flags, the returned statuses, the done count and the final pointer.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DESC_LOG = 3;
  localparam logic [7:0] STAT_READY    = 8'h83;
  localparam logic [7:0] STAT_RETURNED = 8'h03;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam int HDR_STEPS = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_STAT, S_HDR, S_FETCH, S_SEND, S_WB, S_NEXT
  } scan_st_t;

  // header fetch order: length high, length low, addr high, addr low, addr top
  function automatic logic [2:0] hdr_ofs(input logic [2:0] step);
    case (step)
      3'd0:    hdr_ofs = 3'd4;
      3'd1:    hdr_ofs = 3'd5;
      3'd2:    hdr_ofs = 3'd0;
      3'd3:    hdr_ofs = 3'd1;
      default: hdr_ofs = 3'd3;
    endcase
  endfunction
endpackage

// File: rtl/txr_len_dec.sv
module txr_len_dec #(
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 1544
) (
  input  logic [LEN_W-1:0] neg_len_i,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] mag;
  always_comb begin
    mag   = ~neg_len_i + LEN_W'(1);
    len_o = (mag > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : mag;
  end
endmodule

// File: rtl/txr_kick_ctl.sv
module txr_kick_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic stopped_i,
  input  logic scan_end_i,
  output logic start_o,
  output logic busy_o
);
  logic pend_q;

  always_comb begin
    start_o = !stopped_i &&
              ((!busy_o && kick_i) || (scan_end_i && (pend_q || kick_i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (start_o)         busy_o <= 1'b1;
      else if (scan_end_i) busy_o <= 1'b0;
      if (start_o || scan_end_i)  pend_q <= 1'b0;
      else if (busy_o && kick_i)  pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/txr_ring_scan.sv
module txr_ring_scan
  import txr_pkg::*;
#(
  parameter int RING_LOG = 4,
  parameter int RING_OFS = 152,
  parameter int MAX_LEN  = 1544,
  parameter int AW       = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kick_i,
  input  logic                stopped_i,
  input  logic [AW-1:0]       init_ptr_i,
  input  logic [AW-1:0]       dma_off_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [7:0]          mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic [7:0]          mem_rdata_i,
  output logic                tx_valid_o,
  input  logic                tx_ready_i,
  output logic [7:0]          tx_data_o,
  output logic                tx_last_o,
  output logic                tx_done_o,
  output logic                busy_o,
  output logic [RING_LOG-1:0] ptr_o
);
  localparam int LEN_W = 16;
  localparam int RING  = 1 << RING_LOG;
  localparam logic [RING_LOG-1:0] LAST_VISIT = RING_LOG'(RING - 2);

  scan_st_t            st;
  logic [RING_LOG-1:0] idx, visits;
  logic [2:0]          step;
  logic [LEN_W-1:0]    len_raw, len_dec, remain;
  logic [15:0]         buf_lo;
  logic [AW-1:0]       cur_addr, base, desc_addr;
  logic [7:0]          data_q;
  logic                start, scan_end;

  assign base      = init_ptr_i + dma_off_i;
  assign desc_addr = base + AW'(RING_OFS) + (AW'(idx) << DESC_LOG);
  assign scan_end  = (st == S_NEXT) && (visits == LAST_VISIT);

  txr_kick_ctl kick_u (
    .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .stopped_i(stopped_i),
    .scan_end_i(scan_end), .start_o(start), .busy_o(busy_o)
  );

  txr_len_dec #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) len_u (
    .neg_len_i(len_raw), .len_o(len_dec)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (st)
      S_STAT: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_addr + AW'(OFS_STAT);
      end
      S_HDR: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_addr + AW'(hdr_ofs(step));
      end
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_addr;
      end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_addr + AW'(OFS_STAT);
        mem_wdata_o = STAT_RETURNED;
      end
      default: ;
    endcase
  end

  assign tx_data_o = data_q;
  assign tx_last_o = tx_valid_o && (remain == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      visits     <= '0;
      step       <= '0;
      len_raw    <= '0;
      buf_lo     <= '0;
      remain     <= '0;
      cur_addr   <= '0;
      data_q     <= '0;
      tx_valid_o <= 1'b0;
      tx_done_o  <= 1'b0;
      ptr_o      <= '0;
    end else begin
      tx_done_o <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_STAT;
          idx    <= ptr_o;
          visits <= '0;
        end
        S_STAT: if (mem_ack_i) begin
          step <= '0;
          st   <= (mem_rdata_i == STAT_READY) ? S_HDR : S_NEXT;
        end
        S_HDR: if (mem_ack_i) begin
          case (step)
            3'd0: len_raw[15:8] <= mem_rdata_i;
            3'd1: len_raw[7:0]  <= mem_rdata_i;
            3'd2: buf_lo[15:8]  <= mem_rdata_i;
            3'd3: buf_lo[7:0]   <= mem_rdata_i;
            default: ;
          endcase
          if (step == 3'(HDR_STEPS - 1)) begin
            remain   <= len_dec;
            cur_addr <= base + AW'({mem_rdata_i, buf_lo});
            st       <= (len_dec == '0) ? S_WB : S_FETCH;
          end else begin
            step <= step + 3'd1;
          end
        end
        S_FETCH: if (mem_ack_i) begin
          data_q     <= mem_rdata_i;
          tx_valid_o <= 1'b1;
          st         <= S_SEND;
        end
        S_SEND: if (tx_ready_i) begin
          tx_valid_o <= 1'b0;
          remain     <= remain - LEN_W'(1);
          cur_addr   <= cur_addr + AW'(1);
          st         <= (remain == LEN_W'(1)) ? S_WB : S_FETCH;
        end
        S_WB: if (mem_ack_i) begin
          ptr_o     <= ptr_o + RING_LOG'(1);
          tx_done_o <= 1'b1;
          st        <= S_NEXT;
        end
        S_NEXT: begin
          if (scan_end) begin
            if (start) begin
              st     <= S_STAT;
              idx    <= ptr_o;
              visits <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            idx    <= idx + RING_LOG'(1);
            visits <= visits + RING_LOG'(1);
            st     <= S_STAT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txr_ring_scan_chk.sv
module txr_ring_scan_chk #(
  parameter int RING_LOG = 4,
  parameter int AW       = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stopped_i,
  input logic                mem_req_o,
  input logic                mem_we_o,
  input logic [AW-1:0]       mem_addr_o,
  input logic [7:0]          mem_wdata_o,
  input logic                mem_ack_i,
  input logic                tx_valid_o,
  input logic                tx_ready_i,
  input logic [7:0]          tx_data_o,
  input logic                tx_last_o,
  input logic                tx_done_o,
  input logic                busy_o,
  input logic [RING_LOG-1:0] ptr_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_o && !tx_valid_o));

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && stopped_i) |=> !busy_o);

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_o |-> (ptr_o == RING_LOG'($past(ptr_o) + 1'b1)));

  // R6
  ptr_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_done_o |-> $stable(ptr_o));

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=>
      (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
endmodule

bind txr_ring_scan txr_ring_scan_chk #(.RING_LOG(RING_LOG), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .stopped_i(stopped_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
  .tx_last_o(tx_last_o), .tx_done_o(tx_done_o), .busy_o(busy_o), .ptr_o(ptr_o)
);

// File: tb/txr_ring_scan_tb_top.sv
`timescale 1ns/1ps
module txr_ring_scan_tb_top;
  localparam int MSZ  = 8192;
  localparam logic [31:0] INIT = 32'h100, DOFF = 32'h200;
  localparam int BASE = 32'h300;
  localparam int DESC0 = BASE + 152;
  localparam int CAP = 1544;

  logic clk = 0, rst_n = 0, kick_i = 0, stopped_i = 0;
  logic mem_req_o, mem_we_o, mem_ack_i = 0, tx_valid_o, tx_ready_i = 0;
  logic tx_last_o, tx_done_o, busy_o;
  logic [31:0] mem_addr_o;
  logic [7:0] mem_wdata_o, mem_rdata_i = 0, tx_data_o;
  logic [3:0] ptr_o;

  always #2.5 clk = ~clk;

  txr_ring_scan dut_i (
    .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .stopped_i(stopped_i),
    .init_ptr_i(INIT), .dma_off_i(DOFF),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
    .tx_last_o(tx_last_o), .tx_done_o(tx_done_o), .busy_o(busy_o), .ptr_o(ptr_o)
  );

  logic [7:0] mem [0:MSZ-1];
  logic [7:0] sh  [0:MSZ-1];
  logic [7:0] exp_b[$], got_b[$];
  bit exp_l[$], got_l[$];
  int nchk = 0, nerr = 0, exp_done = 0, got_done = 0, req_seen = 0, busy_seen = 0;
  logic [3:0] eptr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory responder and stream consumer, driven at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (busy_o) busy_seen++;
      if (tx_done_o) got_done++;
      tx_ready_i = ($urandom % 4) != 0;
      if (tx_valid_o && tx_ready_i) begin
        got_b.push_back(tx_data_o);
        got_l.push_back(tx_last_o);
      end
      if (mem_ack_i) mem_ack_i = 0;
      else if (mem_req_o) begin
        req_seen++;
        if ($urandom % 2) begin
          mem_ack_i = 1;
          if (mem_we_o) mem[mem_addr_o % MSZ] = mem_wdata_o;
          else mem_rdata_i = mem[mem_addr_o % MSZ];
        end
      end
    end
  end

  function automatic int daddr(input int i);
    return DESC0 + 8 * i;  // R11 descriptor placement
  endfunction

  task automatic set_desc(input int i, input logic [7:0] st, input int n,
                          input int boff);
    logic [15:0] f;
    int d;
    d = daddr(i);
    f = 16'(-n);
    mem[d]   = boff[15:8];
    mem[d+1] = boff[7:0];
    mem[d+2] = st;
    mem[d+3] = 8'h00;
    mem[d+4] = f[15:8];
    mem[d+5] = f[7:0];
    for (int j = 0; j < (n > CAP ? CAP : n); j++)
      mem[(BASE + boff + j) % MSZ] = 8'($urandom);
  endtask

  // reference scan on the shadow copy
  task automatic model_scan();
    logic [3:0] start;
    start = eptr;
    for (int k = 0; k < 15; k++) begin
      int i, d, n, a;
      logic [15:0] f;
      i = (start + k) % 16;
      d = daddr(i);
      if (sh[d+2] == 8'h83) begin
        f = {sh[d+4], sh[d+5]};
        n = int'(16'(~f + 16'd1));
        if (n > CAP) n = CAP;
        a = BASE + {sh[d+3], sh[d], sh[d+1]};
        for (int j = 0; j < n; j++) begin
          exp_b.push_back(sh[(a + j) % MSZ]);
          exp_l.push_back(j == n - 1);
        end
        sh[d+2] = 8'h03;
        eptr = eptr + 4'd1;
        exp_done++;
      end
    end
  endtask

  task automatic run(input string tag, input bit second_kick);
    int t;
    for (int a = 0; a < MSZ; a++) sh[a] = mem[a];
    exp_b.delete(); exp_l.delete(); got_b.delete(); got_l.delete();
    exp_done = 0; got_done = 0;
    model_scan();
    if (second_kick) model_scan();
    @(negedge clk); kick_i = 1;
    @(negedge clk); kick_i = 0;
    if (second_kick) begin
      repeat (3) @(negedge clk);
      kick_i = 1;
      @(negedge clk); kick_i = 0;
    end
    t = 0;
    while (busy_o && t < 40000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    chk(got_b.size() == exp_b.size(), tag, "byte count", got_b.size(), exp_b.size());
    begin
      int bad;
      bad = -1;
      for (int j = 0; j < exp_b.size() && j < got_b.size(); j++)
        if (got_b[j] != exp_b[j] || got_l[j] != exp_l[j]) begin bad = j; break; end
      chk(bad < 0, tag, "R4 R9 data/last at index",
          bad < 0 ? 0 : {got_l[bad], got_b[bad]},
          bad < 0 ? 0 : {exp_l[bad], exp_b[bad]});
    end
    chk(got_done == exp_done, tag, "R6 done pulses", got_done, exp_done);
    chk(ptr_o == eptr, tag, "R6 pointer", ptr_o, eptr);
    for (int i = 0; i < 16; i++)
      if (mem[daddr(i)+2] != sh[daddr(i)+2])
        chk(0, tag, "R3 R6 status byte", mem[daddr(i)+2], sh[daddr(i)+2]);
    nchk++;
  endtask

  initial begin
    int t0;
    void'($urandom(32'd1234));
    for (int a = 0; a < MSZ; a++) mem[a] = 8'($urandom);
    for (int i = 0; i < 16; i++) mem[daddr(i)+2] = 8'h00;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !tx_valid_o && !mem_req_o && !tx_done_o && ptr_o == 0,
        "R1", "reset outputs", {busy_o, tx_valid_o, mem_req_o, tx_done_o, ptr_o}, 0);
    rst_n = 1;
    @(negedge clk);

    // R6 R3: one ready entry away from pointer; pointer moves once
    set_desc(1, 8'h83, 5, 32'h200);
    run("R6 single", 0);

    // R3 R4 R5 R9: near-miss statuses, zero length, oversize length
    set_desc(2, 8'h83, 0, 32'h240);
    set_desc(3, 8'h83, 2000, 32'h1000);
    set_desc(5, 8'h82, 7, 32'h280);
    set_desc(6, 8'hC3, 7, 32'h2C0);
    set_desc(7, 8'h03, 7, 32'h300);
    run("R5 mixed", 0);
    chk(exp_b.size() == CAP, "R5", "model cap", exp_b.size(), CAP);

    // R2: kick while stopped is ignored and not remembered
    stopped_i = 1;
    set_desc(4, 8'h83, 9, 32'h340);
    req_seen = 0; busy_seen = 0; got_b.delete();
    @(negedge clk); kick_i = 1;
    @(negedge clk); kick_i = 0;
    repeat (10) @(negedge clk);
    stopped_i = 0;
    repeat (20) @(negedge clk);
    t0 = req_seen + busy_seen + got_b.size();
    chk(t0 == 0, "R2", "activity while stopped", t0, 0);
    chk(mem[daddr(4)+2] == 8'h83, "R2", "status untouched", mem[daddr(4)+2], 8'h83);

    // R8: full ring, second kick during scan -> one more scan
    for (int i = 0; i < 16; i++) set_desc(i, 8'h83, 1 + $urandom % 32, 32'h200 + i * 64);
    run("R8 pending", 1);
    chk(exp_done == 16, "R8", "model frames", exp_done, 16);

    // R7: full ring, single kick -> 15 frames
    for (int i = 0; i < 16; i++) set_desc(i, 8'h83, 1 + $urandom % 32, 32'h200 + i * 64);
    run("R7 window", 0);
    chk(got_done == 15, "R7", "frames per scan", got_done, 15);

    // random rings
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 16; i++) begin
        logic [7:0] s;
        case ($urandom % 6)
          0: s = 8'h03; 1: s = 8'h81; 2: s = 8'h80;
          default: s = 8'h83;
        endcase
        set_desc(i, s, $urandom % 48, 32'h200 + i * 64);
      end
      run("R4 random", 0);
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule